// File: doc/BRIEF.md
# Streaming Hamming ECC Generator for 256-Byte NAND Blocks

This block sits beside a NAND flash data path and watches every byte that crosses the data window, in either direction. While it is enabled it folds each byte into a single-error-correcting Hamming code over a block of 256 bytes. The result is three code bytes: two bytes of row (line) parity, built from the byte's position within the block, and one byte of column parity, built from bit positions within the byte. Software compares the stored and the freshly computed code and repairs a single flipped bit. That comparison and repair are not part of this block.

A small control register holds an enable bit and an output-inversion bit, and has a clear bit that acts only as a pulse. Writing 0x07 discards the previous code and starts a new one with inverted output. With inversion on, an erased block of all-0xFF bytes yields code bytes of 0xFF. A single 32-bit read at the word offset returns an external status byte with the three code bytes packed above it, so one access collects everything software needs.

Top module: `nand_ecc256_gen`

## Requirements
- R1: After reset the control register reads 0 and, with inversion off, the word readback holds 0x00 in bytes 1 and 2 and 0x03 in byte 3.
- R2: A bus access whose address is below 0x800 counts as a data-window access. If the enable bit is set, the data byte of that access is folded into the code: the write byte on writes and `flash_byte` on reads. If the enable bit is clear, the access leaves the code unchanged.
- R3: Accesses at addresses of 0x800 and above never change the code.
- R4: Row parity is 16 bits. For each bit k of the 8-bit byte index, bit 2k+1 accumulates the XOR of all bits of the bytes whose index has bit k set, and bit 2k accumulates the same over the bytes whose index has bit k clear. Bits 7..0 go to byte 1 of the word and bits 15..8 go to byte 2.
- R5: Column parity is six bits taken from the XOR of all accepted bytes. Bits 2k+1 and 2k are the parities of the byte bits whose position has bit k set and clear, for k = 0..2. They sit in bits 7..2 of byte 3, and bits 1..0 of byte 3 always read 1.
- R6: Control bit 2 selects inverted output: all 22 parity bits are complemented on readback, so a full block of 0xFF bytes reads 0xFF in bytes 1 to 3. Changing this bit alone changes the readback and leaves the accumulated state as it was.
- R7: A control write with bit 1 set zeroes the parities and the byte index. Bit 1 always reads back 0.
- R8: The control register sits at 0x814, with bit 0 enable and bit 2 inversion. Reading it returns those bits in place and zero elsewhere.
- R9: A read at 0x810 returns `stat_byte` in byte 0, row parity bits 7..0 in byte 1, bits 15..8 in byte 2 and the column byte in byte 3.
- R10: Once 256 bytes have been accepted, further window accesses are ignored until a clear.
- R11: A byte accepted on one clock edge is visible in the word readback directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | An access takes place this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address within the controller space |
| bus_wdata | input | 8 | Write byte |
| flash_byte | input | 8 | Byte returned by the flash on window reads |
| stat_byte | input | 8 | Controller status placed in byte 0 of the word readback |
| rd_data | output | 32 | Read data for the addressed register, zero elsewhere |

## Verification
The hardest state to reach from the ports is the saturated block. Getting there takes exactly 256 accepted bytes followed by one more window access, and that extra access must be shown to have no effect even though, if it were accepted, its index would wrap back to zero. The bench fills a block with 0xFF in raw mode, flips only the inversion bit to show that the stored parities are untouched, then sends a byte of odd parity and checks that the word is unchanged. Single-byte vectors placed behind runs of zero bytes then move an odd-parity byte to chosen indices, which drives every row-parity bit one at a time.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // Column parity: for each of the three bit-position address bits k,
  // bit 2k+1 covers positions with bit k set, bit 2k those with it clear.
  function automatic logic [5:0] col_par6(input logic [7:0] x);
    logic [5:0] cp;
    cp = '0;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> k) & 1) == 1) cp[2*k+1] = cp[2*k+1] ^ x[b];
        else                     cp[2*k]   = cp[2*k]   ^ x[b];
      end
    end
    return cp;
  endfunction

  typedef struct packed {
    logic inv;
    logic en;
  } ecc_ctl_t;

endpackage

// File: rtl/nand_ecc_dec.sv
module nand_ecc_dec #(
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 2048,
  parameter int WORD_ADDR = 'h810,
  parameter int CTL_ADDR  = 'h814
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic              ctl_wr,
  output logic              sel_word,
  output logic              sel_ctl
);
  localparam logic [ADDR_W-1:0] WinLimit = ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] WordA    = ADDR_W'(WORD_ADDR);
  localparam logic [ADDR_W-1:0] CtlA     = ADDR_W'(CTL_ADDR);

  always_comb begin
    win_hit  = valid && (addr < WinLimit);
    sel_word = (addr == WordA);
    sel_ctl  = (addr == CtlA);
    ctl_wr   = valid && write && sel_ctl;
  end
endmodule

// File: rtl/nand_ecc_line.sv
module nand_ecc_line #(
  parameter int BLOCK_BYTES = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           go,
  input  logic                           clr,
  input  logic [7:0]                     data,
  output logic [2*$clog2(BLOCK_BYTES)-1:0] lp_o,
  output logic                           full_o
);
  localparam int IDX_W = $clog2(BLOCK_BYTES);
  localparam int LP_W  = 2 * IDX_W;
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(BLOCK_BYTES);

  logic [LP_W-1:0]  lp_q, lp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx;
  logic             bpar;
  logic             upd_en;

  assign idx    = cnt_q[IDX_W-1:0];
  assign bpar   = ^data;
  assign full_o = (cnt_q == CntMax);
  assign lp_o   = lp_q;
  assign upd_en = clr | go;

  always_comb begin
    lp_d  = lp_q;
    cnt_d = cnt_q;
    if (clr) begin
      lp_d  = '0;
      cnt_d = '0;
    end else if (go) begin
      cnt_d = cnt_q + 1'b1;
      for (int k = 0; k < IDX_W; k++) begin
        if (idx[k]) lp_d[2*k+1] = lp_q[2*k+1] ^ bpar;
        else        lp_d[2*k]   = lp_q[2*k]   ^ bpar;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      lp_q  <= lp_d;
      cnt_q <= cnt_d;
    end
  end

  // R10: the index counter never runs past one block
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CntMax);
  // R10: the caller never offers a byte once the block is complete
  p_go_not_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !full_o);
  // R10: a complete block stays complete until cleared
  p_full_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clr) |=> full_o);
endmodule

// File: rtl/nand_ecc_col.sv
module nand_ecc_col
  import nand_ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       clr,
  input  logic [7:0] data,
  output logic [5:0] cp_o
);
  logic [7:0] colx_q, colx_d;
  logic       upd_en;

  assign upd_en = clr | go;

  always_comb begin
    colx_d = colx_q;
    if (clr)     colx_d = '0;
    else if (go) colx_d = colx_q ^ data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      colx_q <= '0;
    else if (upd_en) colx_q <= colx_d;
  end

  assign cp_o = col_par6(colx_q);

  // R3: without an accepted byte or a clear the column state holds
  p_col_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !clr) |=> $stable(colx_q));
endmodule

// File: rtl/nand_ecc256_gen.sv
module nand_ecc256_gen
  import nand_ecc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WIN_BYTES   = 2048,
  parameter int WORD_ADDR   = 'h810,
  parameter int CTL_ADDR    = 'h814,
  parameter int BLOCK_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [7:0]        flash_byte,
  input  logic [7:0]        stat_byte,
  output logic [31:0]       rd_data
);
  localparam int IDX_W = $clog2(BLOCK_BYTES);
  localparam int LP_W  = 2 * IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic win_hit, ctl_wr, sel_word, sel_ctl;

  nand_ecc_dec #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
    .WORD_ADDR(WORD_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .win_hit(win_hit), .ctl_wr(ctl_wr), .sel_word(sel_word), .sel_ctl(sel_ctl)
  );

  // control register: enable and inversion stored, clear is a pulse
  ecc_ctl_t ctl_q, ctl_d;
  logic     clr;

  assign clr = ctl_wr & bus_wdata[1];

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d.en  = bus_wdata[0];
      ctl_d.inv = bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_d;
  end

  logic            full, go;
  logic [7:0]      acc_byte;
  logic [LP_W-1:0] lp;
  logic [5:0]      cp;

  assign acc_byte = bus_write ? bus_wdata : flash_byte;
  assign go       = win_hit & ctl_q.en & ~full;

  nand_ecc_line #(.BLOCK_BYTES(BLOCK_BYTES)) u_line (
    .clk(clk), .rst_n(rst_n_s), .go(go), .clr(clr),
    .data(acc_byte), .lp_o(lp), .full_o(full)
  );

  nand_ecc_col u_col (
    .clk(clk), .rst_n(rst_n_s), .go(go), .clr(clr),
    .data(acc_byte), .cp_o(cp)
  );

  // readback packing
  logic [15:0] lp16;
  logic [7:0]  lsb_b, msb_b, col_b;

  always_comb begin
    lp16  = 16'(lp);
    lsb_b = ctl_q.inv ? ~lp16[7:0]  : lp16[7:0];
    msb_b = ctl_q.inv ? ~lp16[15:8] : lp16[15:8];
    col_b = {(ctl_q.inv ? ~cp : cp), 2'b11};
    if (sel_word)     rd_data = {col_b, msb_b, lsb_b, stat_byte};
    else if (sel_ctl) rd_data = {29'd0, ctl_q.inv, 1'b0, ctl_q.en};
    else              rd_data = '0;
  end

  // R7: a clear write leaves zero parities after the edge
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr |=> (lp == '0) && (cp == '0));
  // R2: with enable off, window traffic leaves the parities untouched
  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctl_q.en && !clr) |=> $stable(lp) && $stable(cp));
  // R3: accesses outside the window leave the row parity untouched
  p_offwin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!win_hit && !clr) |=> $stable(lp));
  // R10: a complete block ignores further bytes
  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (full && !clr) |=> $stable(lp) && $stable(cp));
endmodule

// File: tb/sim_nand_ecc256_gen.sv
module sim_nand_ecc256_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] WORD_A = 12'h810;
  localparam logic [11:0] CTL_A  = 12'h814;
  localparam logic [7:0]  STAT   = 8'h5C;

  // vector: {is_read, inv, index, value, expected {col,msb,lsb}}
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 8'h01, 24'h575555},
    {1'b0, 1'b0, 8'hFF, 8'h80, 24'hABAAAA},
    {1'b1, 1'b0, 8'h0F, 8'h03, 24'h0F0000},
    {1'b0, 1'b0, 8'h35, 8'h10, 24'h975A66},
    {1'b1, 1'b0, 8'hA0, 8'h07, 24'h6B9955},
    {1'b0, 1'b1, 8'h00, 8'h01, 24'hABAAAA}
  };

  logic        clk, rst_n;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, flash_byte, stat_byte;
  logic [31:0] rd_data;

  int n_chk, n_fail;
  bit done;

  nand_ecc256_gen u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flash_byte(flash_byte),
    .stat_byte(stat_byte), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic bus_cycle(input logic wr, input logic [11:0] a, input logic [7:0] wd, input logic [7:0] fb);
    bus_valid  = 1'b1;
    bus_write  = wr;
    bus_addr   = a;
    bus_wdata  = wd;
    flash_byte = fb;
    @(negedge clk);
    bus_valid  = 1'b0;
  endtask

  task automatic win_byte(input logic rd, input logic [7:0] v);
    if (rd) bus_cycle(1'b0, 12'h123, 8'h00, v);
    else    bus_cycle(1'b1, 12'h456, v, 8'h00);
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] v);
    bus_valid = 1'b0;
    bus_addr  = a;
    #1;
    v = rd_data;
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    n_chk = 0; n_fail = 0;
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    flash_byte = '0; stat_byte = STAT;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R8: reset state of control; R1 R9: word packing at reset
    reg_read(CTL_A, r);  check("R1 R8 ctl after reset", r, 32'h0);
    reg_read(WORD_A, r); check("R1 R9 word after reset", r, {24'h030000, STAT});

    // vector table: one odd byte behind a run of zero bytes (R2 R4 R5 R6 R11)
    for (int v = 0; v < NV; v++) begin
      logic        isrd, inv;
      logic [7:0]  idx, val;
      logic [23:0] exp;
      {isrd, inv, idx, val, exp} = VEC[v];
      bus_cycle(1'b1, CTL_A, {5'd0, inv, 2'b11}, 8'h00);
      for (int i = 0; i < int'(idx); i++) win_byte(isrd, 8'h00);
      win_byte(isrd, val);
      reg_read(WORD_A, r);
      check($sformatf("R4 R5 R11 vector %0d", v), r, {exp, STAT});
    end

    // R7 R8: clear pulse reads 0, enable and inversion read back in place
    bus_cycle(1'b1, CTL_A, 8'h07, 8'h00);
    reg_read(CTL_A, r);  check("R7 R8 ctl readback", r, 32'h5);
    stat_byte = 8'hA3;
    reg_read(WORD_A, r); check("R7 R9 cleared inverted word", r, 32'hFFFFFFA3);
    stat_byte = STAT;

    // R3: traffic outside the window
    bus_cycle(1'b1, 12'h900, 8'h01, 8'h00);
    bus_cycle(1'b1, WORD_A, 8'h01, 8'h00);
    bus_cycle(1'b0, 12'h800, 8'h00, 8'h01);
    reg_read(WORD_A, r); check("R3 off-window ignored", r, {24'hFFFFFF, STAT});

    // R2: enable off
    bus_cycle(1'b1, CTL_A, 8'h04, 8'h00);
    win_byte(1'b0, 8'h01);
    win_byte(1'b1, 8'h80);
    reg_read(WORD_A, r); check("R2 disabled ignored", r, {24'hFFFFFF, STAT});

    // R6 R10: full erased block in raw mode, then inversion alone
    bus_cycle(1'b1, CTL_A, 8'h03, 8'h00);
    for (int i = 0; i < 256; i++) win_byte(1'b0, 8'hFF);
    reg_read(WORD_A, r); check("R6 erased block raw", r, {24'h030000, STAT});
    bus_cycle(1'b1, CTL_A, 8'h05, 8'h00);
    reg_read(WORD_A, r); check("R6 erased block inverted", r, {24'hFFFFFF, STAT});

    // R10: byte 257 has odd parity and must be ignored
    win_byte(1'b0, 8'h01);
    win_byte(1'b1, 8'h80);
    reg_read(WORD_A, r); check("R10 block full ignores bytes", r, {24'hFFFFFF, STAT});

    // R7 R10: clear restarts the index, block accepts again
    bus_cycle(1'b1, CTL_A, 8'h03, 8'h00);
    reg_read(WORD_A, r); check("R7 cleared raw word", r, {24'h030000, STAT});
    win_byte(1'b0, 8'h01);
    reg_read(WORD_A, r); check("R7 R10 index 0 after clear", r, {24'h575555, STAT});

    // R11 R4 R5: second byte at index 1 folds in directly after its edge
    win_byte(1'b1, 8'h80);
    reg_read(WORD_A, r); check("R11 R4 R5 second byte", r, {24'hFF0003, STAT});

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule